// File: doc/BRIEF.md
# Four-stage pipelined 8-bit processor core

This block is a small load/store processor with an 8-bit datapath. Instructions flow through four pipeline stages: fetch, decode, execute, and a last stage where data memory access and register write-back share one cycle. Each instruction is a 24-bit word read from an internal 256-entry instruction memory addressed by the program counter.

An instruction names an opcode, two registers out of eight, and a 10-bit direct data address. The execute stage computes arithmetic and logic results and keeps a three-flag status word. It also resolves jumps and the branch-on-zero. There is no interlock and no forwarding network, so software must place dependent instructions far enough apart. A preload port lets a testbench fill either memory while the core is held in reset. Debug outputs show the program counter, the register-file write port and the status word.

Top module: `pipe4_cpu8`

## Requirements
- R1: A synchronous active-high `rst` clears the PC to 0 and the status word to 0. It empties every pipeline register to NOP and clears all eight registers. While reset is held, `dbg_wr_en` stays low. A register read after reset returns 0.
- R2: Instruction fields: opcode in bits 23:16, register A in bits 15:13, register B in bits 12:10, direct address in bits 9:0. Register A is both the first source and the destination.
- R3: Without a taken branch, the PC advances by one on each clock edge out of reset, so it reads 3 after three edges.
- R4: Opcodes 0x01 ADD, 0x02 SUB (A-B), 0x03 AND, 0x04 OR and 0x05 XOR write their 8-bit result into register A.
- R5: `dbg_psw` bit 0 is zero, bit 1 is carry and bit 2 is negative (result bit 7). Carry is the carry-out on ADD and the borrow (A<B) on SUB, and it is cleared by AND, OR and XOR. Only opcodes 0x01 to 0x05 update the status word.
- R6: Opcode 0x0A MOV copies register B into register A and leaves the status word unchanged.
- R7: Opcode 0x06 LOAD writes data memory at the 10-bit address into register A. Opcode 0x07 STORE writes register A to that address and writes no register. A LOAD directly after a STORE to the same address returns the stored byte.
- R8: Opcodes 0x08 JMP (always) and 0x09 BZ (when the zero flag is 1) are resolved in execute. The next PC becomes address bits 7:0, and the two instructions fetched after the branch are discarded without effect.
- R9: Any opcode outside 0x00 to 0x0A behaves as a NOP. It writes no register, does not touch memory or flags, and does not branch.
- R10: A register written by an instruction is read with its new value by the instruction two places later, because the register file passes the write through.
- R11: With no interlock, the instruction directly after a writer reads the register's old value.
- R12: While `ld_we` is high, `ld_dmem`=0 writes `ld_data` to instruction memory at `ld_addr[7:0]`. `ld_dmem`=1 writes `ld_data[7:0]` to data memory at `ld_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Preload write strobe |
| ld_dmem | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| ld_addr | input | 10 | Preload address |
| ld_data | input | 24 | Preload data (low 8 bits for data memory) |
| dbg_pc | output | 8 | Current fetch address |
| dbg_wr_en | output | 1 | Register write happening this cycle |
| dbg_wr_addr | output | 3 | Register being written |
| dbg_wr_data | output | 8 | Value being written |
| dbg_psw | output | 3 | Status word {negative, carry, zero} |

## Verification
A table of operand pairs runs each ALU opcode through the same small program. It loads two operands, operates, branches on zero and copies the result. The pairs are chosen to separate carry-out from no carry, borrow from no borrow, zero from non-zero results, and set from clear sign bits. The branch path taken in each run shows whether the zero flag drove BZ and whether the two younger instructions were discarded. Directed programs place a reader one and then two slots after a writer, which separates the missing interlock from the write-through register file. They also pair a store with a load at the top data address and check that reset clears registers written by an earlier run.

// File: rtl/pipe4_cpu8.sv
module pipe4_cpu8 #(
  parameter int IW     = 24,
  parameter int DW     = 8,
  parameter int NREG   = 8,
  parameter int IDEPTH = 256,
  parameter int DDEPTH = 1024
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ld_we,
  input  logic                      ld_dmem,
  input  logic [$clog2(DDEPTH)-1:0] ld_addr,
  input  logic [IW-1:0]             ld_data,
  output logic [$clog2(IDEPTH)-1:0] dbg_pc,
  output logic                      dbg_wr_en,
  output logic [$clog2(NREG)-1:0]   dbg_wr_addr,
  output logic [DW-1:0]             dbg_wr_data,
  output logic [2:0]                dbg_psw
);
  localparam int PCW = $clog2(IDEPTH);
  localparam int RAW = $clog2(NREG);
  localparam int DAW = $clog2(DDEPTH);
  localparam int OPW = IW - 2*RAW - DAW;
  localparam int RA_LO = DAW + RAW;
  localparam int RB_LO = DAW;

  localparam logic [OPW-1:0] OP_NOP = 'h00, OP_ADD = 'h01, OP_SUB = 'h02,
    OP_AND = 'h03, OP_OR = 'h04, OP_XOR = 'h05, OP_LD = 'h06, OP_ST = 'h07,
    OP_JMP = 'h08, OP_BZ = 'h09, OP_MOV = 'h0A;

  logic [IW-1:0]  imem [IDEPTH];
  logic [DW-1:0]  dmem [DDEPTH];
  logic [DW-1:0]  rf   [NREG];

  logic [PCW-1:0] pc;
  logic [IW-1:0]  fd_ir;
  logic [OPW-1:0] de_op, ew_op;
  logic [RAW-1:0] de_ra, ew_ra;
  logic [DW-1:0]  de_va, de_vb, ew_res;
  logic [DAW-1:0] de_addr, ew_addr;
  logic [2:0]     psw;

  // decode fields
  wire [OPW-1:0] fd_op   = fd_ir[IW-1:RA_LO+RAW];
  wire [RAW-1:0] fd_ra   = fd_ir[RA_LO+RAW-1:RA_LO];
  wire [RAW-1:0] fd_rb   = fd_ir[RB_LO+RAW-1:RB_LO];
  wire [DAW-1:0] fd_addr = fd_ir[DAW-1:0];

  // memory / write-back stage
  wire          wb_we   = (ew_op >= OP_ADD && ew_op <= OP_LD) || ew_op == OP_MOV;
  wire [DW-1:0] wb_data = (ew_op == OP_LD) ? dmem[ew_addr] : ew_res;

  // register reads with write-first pass-through
  wire [DW-1:0] rd_a = (wb_we && ew_ra == fd_ra) ? wb_data : rf[fd_ra];
  wire [DW-1:0] rd_b = (wb_we && ew_ra == fd_rb) ? wb_data : rf[fd_rb];

  // execute stage
  logic [DW:0] sum;
  always_comb begin
    case (de_op)
      OP_ADD:  sum = {1'b0, de_va} + {1'b0, de_vb};
      OP_SUB:  sum = {1'b0, de_va} - {1'b0, de_vb};
      OP_AND:  sum = {1'b0, de_va & de_vb};
      OP_OR:   sum = {1'b0, de_va | de_vb};
      OP_XOR:  sum = {1'b0, de_va ^ de_vb};
      OP_MOV:  sum = {1'b0, de_vb};
      default: sum = {1'b0, de_va};
    endcase
  end
  wire is_alu = de_op >= OP_ADD && de_op <= OP_XOR;
  wire taken  = de_op == OP_JMP || (de_op == OP_BZ && psw[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      fd_ir <= '0;
      de_op <= OP_NOP; de_ra <= '0; de_va <= '0; de_vb <= '0; de_addr <= '0;
      ew_op <= OP_NOP; ew_ra <= '0; ew_res <= '0; ew_addr <= '0;
      psw   <= '0;
    end else begin
      pc      <= taken ? de_addr[PCW-1:0] : pc + 1'b1;
      fd_ir   <= taken ? '0 : imem[pc];
      de_op   <= taken ? OP_NOP : fd_op;
      de_ra   <= fd_ra;
      de_va   <= rd_a;
      de_vb   <= rd_b;
      de_addr <= fd_addr;
      ew_op   <= de_op;
      ew_ra   <= de_ra;
      ew_res  <= sum[DW-1:0];
      ew_addr <= de_addr;
      if (is_alu) psw <= {sum[DW-1], sum[DW], sum[DW-1:0] == '0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (wb_we) begin
      rf[ew_ra] <= wb_data;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_we && !ld_dmem) imem[ld_addr[PCW-1:0]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_we && ld_dmem)   dmem[ld_addr] <= ld_data[DW-1:0];
    else if (ew_op == OP_ST) dmem[ew_addr] <= ew_res;
  end

  assign dbg_pc      = pc;
  assign dbg_wr_en   = wb_we;
  assign dbg_wr_addr = ew_ra;
  assign dbg_wr_data = wb_data;
  assign dbg_psw     = psw;

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (pc == '0 && psw == '0 && !dbg_wr_en));

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
    !taken |=> pc == $past(pc) + 1'b1);

  assert_branch_target_R8: assert property (@(posedge clk) disable iff (rst)
    taken |=> pc == $past(de_addr[PCW-1:0]));

  assert_flush_first_R8: assert property (@(posedge clk) disable iff (rst)
    taken |-> ##2 !dbg_wr_en);

  assert_flush_second_R8: assert property (@(posedge clk) disable iff (rst)
    taken |-> ##3 !dbg_wr_en);

  assert_psw_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !is_alu |=> $stable(psw));

  assert_store_nowrite_R7: assert property (@(posedge clk) disable iff (rst)
    ew_op == OP_ST |-> !dbg_wr_en);

  assert_undef_nowrite_R9: assert property (@(posedge clk) disable iff (rst)
    ew_op > OP_MOV |-> !dbg_wr_en);
endmodule

// File: tb/sim_pipe4_cpu8.sv
`timescale 1ns/1ps
module sim_pipe4_cpu8;
  logic clk = 1'b0, rst = 1'b1;
  logic ld_we = 1'b0, ld_dmem = 1'b0;
  logic [9:0]  ld_addr = '0;
  logic [23:0] ld_data = '0;
  logic [7:0]  dbg_pc, dbg_wr_data;
  logic        dbg_wr_en;
  logic [2:0]  dbg_wr_addr, dbg_psw;

  always #4 clk = ~clk;

  pipe4_cpu8 u0 (.clk, .rst, .ld_we, .ld_dmem, .ld_addr, .ld_data,
                 .dbg_pc, .dbg_wr_en, .dbg_wr_addr, .dbg_wr_data, .dbg_psw);

  int total = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] sh [8];
  int         cnt [8];

  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) begin sh[i] <= '0; cnt[i] <= 0; end
    end else if (dbg_wr_en) begin
      sh[dbg_wr_addr]  <= dbg_wr_data;
      cnt[dbg_wr_addr] <= cnt[dbg_wr_addr] + 1;
    end
  end

  function automatic logic [23:0] ins(input logic [7:0] op, input logic [2:0] a,
                                      input logic [2:0] b, input logic [9:0] ad);
    return {op, a, b, ad};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic ld(input bit dm, input logic [9:0] a, input logic [23:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_dmem = dm; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic hold_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 12; i++) ld(1'b0, 10'(i), 24'h0);
  endtask

  task automatic run(input int n);
    @(negedge clk); rst = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // {op, a, b, result, psw{N,C,Z}}
  localparam int NV = 13;
  localparam logic [34:0] VEC [NV] = '{
    {8'h01, 8'h12, 8'h34, 8'h46, 3'b000},
    {8'h01, 8'hF0, 8'h20, 8'h10, 3'b010},
    {8'h01, 8'h80, 8'h80, 8'h00, 3'b011},
    {8'h02, 8'h50, 8'h30, 8'h20, 3'b000},
    {8'h02, 8'h30, 8'h50, 8'hE0, 3'b110},
    {8'h02, 8'h77, 8'h77, 8'h00, 3'b001},
    {8'h03, 8'hF0, 8'h0F, 8'h00, 3'b001},
    {8'h03, 8'hCC, 8'hAA, 8'h88, 3'b100},
    {8'h04, 8'h0C, 8'h30, 8'h3C, 3'b000},
    {8'h05, 8'hA5, 8'hFF, 8'h5A, 3'b000},
    {8'h05, 8'h81, 8'h01, 8'h80, 3'b100},
    {8'h0A, 8'h00, 8'h9C, 8'h9C, 3'b000},
    {8'h3F, 8'h11, 8'h22, 8'h11, 3'b000}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    // R1, R3: reset state and PC stepping over an all-NOP program
    hold_reset();
    clear_prog();
    @(negedge clk);
    chk(dbg_pc == 8'd0, "R1 pc in reset", dbg_pc, 0);
    chk(dbg_psw == 3'b000, "R1 psw in reset", dbg_psw, 0);
    chk(!dbg_wr_en, "R1 write port quiet in reset", dbg_wr_en, 0);
    run(3);
    chk(dbg_pc == 8'd3, "R3 pc after three edges", dbg_pc, 3);

    // R2, R4, R5, R6, R8, R9, R12: one program per table entry
    for (int v = 0; v < NV; v++) begin
      logic [7:0] op, a, b, res;
      logic [2:0] fl;
      {op, a, b, res, fl} = VEC[v];
      hold_reset();
      ld(1'b1, 10'd0, {16'h0, a});
      ld(1'b1, 10'd1, {16'h0, b});
      ld(1'b0, 10'd0, ins(8'h06, 3'd1, 3'd0, 10'd0));
      ld(1'b0, 10'd1, ins(8'h06, 3'd2, 3'd0, 10'd1));
      ld(1'b0, 10'd2, 24'h0);
      ld(1'b0, 10'd3, ins(op,    3'd1, 3'd2, 10'd0));
      ld(1'b0, 10'd4, ins(8'h09, 3'd0, 3'd0, 10'd8));
      ld(1'b0, 10'd5, ins(8'h0A, 3'd3, 3'd1, 10'd0));
      ld(1'b0, 10'd6, ins(8'h08, 3'd0, 3'd0, 10'd6));
      ld(1'b0, 10'd7, 24'h0);
      ld(1'b0, 10'd8, ins(8'h0A, 3'd4, 3'd1, 10'd0));
      ld(1'b0, 10'd9, ins(8'h08, 3'd0, 3'd0, 10'd9));
      run(25);
      chk(sh[1] == res, $sformatf("R4/R6/R9 result op=%0h", op), sh[1], res);
      chk(dbg_psw == fl, $sformatf("R5 flags op=%0h", op), dbg_psw, fl);
      chk((cnt[4] == 1) == fl[0] && (cnt[3] == 1) == !fl[0] && cnt[3] + cnt[4] == 1,
          $sformatf("R8 branch path op=%0h (r3/r4 writes)", op),
          cnt[3] * 16 + cnt[4], fl[0] ? 1 : 16);
    end

    // R7, R10, R11: hazard spacing and store/load at the top address
    hold_reset();
    clear_prog();
    ld(1'b1, 10'd0, 24'h5B);
    ld(1'b0, 10'd0, ins(8'h06, 3'd1, 3'd0, 10'd0));
    ld(1'b0, 10'd1, ins(8'h0A, 3'd2, 3'd1, 10'd0));
    ld(1'b0, 10'd2, ins(8'h0A, 3'd3, 3'd1, 10'd0));
    ld(1'b0, 10'd3, ins(8'h07, 3'd1, 3'd0, 10'h3FF));
    ld(1'b0, 10'd4, ins(8'h06, 3'd5, 3'd0, 10'h3FF));
    ld(1'b0, 10'd5, ins(8'h08, 3'd0, 3'd0, 10'd5));
    run(20);
    chk(sh[2] == 8'h00 && cnt[2] == 1, "R11 reader right after writer sees old value", sh[2], 0);
    chk(sh[3] == 8'h5B, "R10 reader two slots later sees new value", sh[3], 8'h5B);
    chk(sh[5] == 8'h5B, "R7 load after store at 0x3FF", sh[5], 8'h5B);
    chk(cnt[0] + cnt[1] + cnt[2] + cnt[3] + cnt[4] + cnt[5] + cnt[6] + cnt[7] == 4,
        "R7 store writes no register", cnt[0] + cnt[1] + cnt[2] + cnt[3] + cnt[5], 4);

    // R1: reset clears registers written by the previous run
    hold_reset();
    ld(1'b0, 10'd0, ins(8'h0A, 3'd2, 3'd1, 10'd0));
    ld(1'b0, 10'd1, ins(8'h08, 3'd0, 3'd0, 10'd1));
    run(12);
    chk(sh[2] == 8'h00 && cnt[2] == 1, "R1 register cleared by reset", sh[2], 0);
    chk(dbg_psw == 3'b000, "R1 psw after reset and MOV", dbg_psw, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule